// File: doc/BRIEF.md
# Dual-Bank Ping-Pong Buffer Controller

This controller hands two independent memory banks back and forth between a block-transfer producer and a streaming consumer. The producer writes one fixed-size chunk into a bank per request. The consumer reads one whole bank per request and feeds a display. Each side has a request/done handshake, and the controller chooses the bank for each request. A full flag for each bank records whether that bank holds a chunk that has not yet been read.

After `start`, the controller loads bank 0 and then bank 1 before it lets the consumer run. From then on, fills and drains always use opposite banks. A bank becomes available to the producer only after its drain is done, and available to the consumer only after its fill is done. The two banks therefore swap roles once both the fill of one and the drain of the other have finished.

When the consumer finishes before the next bank is loaded, the controller raises an underrun indication and holds the consumer until that bank is loaded. A chunk index counts drained chunks modulo the number of chunks in a frame. A one-cycle pulse marks the start of each frame. A synchronous stop drops any drain in progress and lets a fill in flight complete. The controller then returns to idle with both banks empty.

Top module: `pingpong_bank_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `fill_req`, `drain_req`, `frame_start`, `underrun` and `busy` are 0, `bank_full` is 2'b00 and `chunk_index` is 0.
- R2: After a `start` pulse, the first fill targets bank 0 and the second fill targets bank 1. `drain_req` stays low until both fills have completed.
- R3: Successive fills alternate banks starting at bank 0. Successive drains alternate banks starting at bank 0.
- R4: Whenever `fill_req` and `drain_req` are both high, `fill_bank` differs from `drain_bank`.
- R5: A drain is only requested on a bank whose `bank_full` bit is 1. A fill is only requested on a bank whose `bank_full` bit is 0. Bit b of `bank_full` is bank b.
- R6: The consumer receives chunks in the order the producer wrote them, with none lost and none repeated.
- R7: On the cycle after a `drain_done`, `underrun` is 1 exactly when the bank the consumer needs next is not full. While `underrun` is 1, `drain_req` stays 0. `underrun` clears when the next drain is requested.
- R8: `chunk_index` counts completed drains modulo FRAME_BYTES/CHUNK_BYTES. `frame_start` is high for exactly the first cycle of a drain request whose `chunk_index` is 0, and is 0 at all other times.
- R9: A `stop` pulse drops any pending drain and issues no new request. It waits for a fill in flight to receive `fill_done`, then makes `busy` 0 with `bank_full` 2'b00. A later `start` fills bank 0 first.
- R10: `fill_req` and `drain_req` stay high with a stable bank select until their `fill_done` or `drain_done` is seen. The only exception is a `stop`, which drops a drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins streaming from idle |
| stop | input | 1 | One-cycle pulse that winds streaming down to idle |
| fill_done | input | 1 | Producer has written the requested chunk |
| drain_done | input | 1 | Consumer has read the requested bank |
| fill_req | output | 1 | Request the producer to fill `fill_bank` |
| fill_bank | output | 1 | Bank targeted by the fill |
| drain_req | output | 1 | Request the consumer to read `drain_bank` |
| drain_bank | output | 1 | Bank handed to the consumer |
| frame_start | output | 1 | Pulse on the first cycle of a frame's first drain |
| chunk_index | output | CW | Position of the current chunk within its frame |
| bank_full | output | 2 | Per-bank full flags, bit b for bank b |
| underrun | output | 1 | Consumer is waiting on a bank that is not yet full |
| busy | output | 1 | Controller is not idle |

## Verification
The bench builds the controller with 16-byte chunks and 48-byte frames, so a frame is three chunks long. A run of seven chunks therefore crosses two frame wraps of the chunk index and the frame pulse. Producer and consumer models with short, adjustable latencies keep the bank alternation, the ordering of chunks held in two modelled banks and repeated underrun stalls within a few hundred cycles. Separate scenarios stop the controller while a fill is in flight and while a drain is in progress.

// File: rtl/pp_pkg.sv
package pp_pkg;

    typedef enum logic [1:0] {
        CTL_IDLE = 2'd0,
        CTL_RUN  = 2'd1,
        CTL_STOP = 2'd2
    } ctl_state_e;

    localparam int NUM_BANKS = 2;

    function automatic int idx_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    function automatic logic [NUM_BANKS-1:0] bank_mask(input logic bank, input logic en);
        logic [NUM_BANKS-1:0] m;
        m = '0;
        if (en) m[bank] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pp_fill_sched.sv
module pp_fill_sched
    import pp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 enable,
    input  logic [NUM_BANKS-1:0] full,
    input  logic                 drain_req,
    input  logic                 drain_bank,
    input  logic                 fill_done,
    output logic                 fill_req,
    output logic                 fill_bank
);
    logic wr_sel;
    logic target_free;

    // the bank may be written only when empty and not being read
    assign target_free = !full[wr_sel] && !(drain_req && (drain_bank == wr_sel));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fill_req <= 1'b0;
            wr_sel   <= 1'b0;
        end else if (fill_req) begin
            if (fill_done) begin
                fill_req <= 1'b0;
                wr_sel   <= ~wr_sel;
            end
        end else if (enable && target_free) begin
            fill_req <= 1'b1;
        end
    end

    assign fill_bank = wr_sel;

endmodule

// File: rtl/pp_drain_sched.sv
module pp_drain_sched
    import pp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 enable,
    input  logic                 abort,
    input  logic [NUM_BANKS-1:0] full,
    input  logic [NUM_BANKS-1:0] landing,
    input  logic                 drain_done,
    output logic                 issue,
    output logic                 drain_req,
    output logic                 drain_bank,
    output logic                 underrun
);
    logic rd_sel;
    logic other_sel;
    logic next_ready;

    assign other_sel  = ~rd_sel;
    assign next_ready = full[other_sel] | landing[other_sel];
    assign issue      = enable && !drain_req && full[rd_sel];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            drain_req <= 1'b0;
            rd_sel    <= 1'b0;
            underrun  <= 1'b0;
        end else if (abort) begin
            drain_req <= 1'b0;
            underrun  <= 1'b0;
        end else if (drain_req) begin
            if (drain_done) begin
                drain_req <= 1'b0;
                rd_sel    <= other_sel;
                underrun  <= !next_ready;
            end
        end else if (issue) begin
            drain_req <= 1'b1;
            underrun  <= 1'b0;
        end
    end

    assign drain_bank = rd_sel;

endmodule

// File: rtl/pp_chunk_ctr.sv
module pp_chunk_ctr #(
    parameter int CHUNKS = 10,
    parameter int CW     = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          issue,
    input  logic          done,
    output logic          frame_start,
    output logic [CW-1:0] idx
);
    localparam logic [CW-1:0] LAST = CW'(CHUNKS - 1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx         <= '0;
            frame_start <= 1'b0;
        end else begin
            frame_start <= issue && (idx == '0);
            if (done) idx <= (idx == LAST) ? '0 : idx + 1'b1;
        end
    end

endmodule

// File: rtl/pingpong_bank_ctrl.sv
module pingpong_bank_ctrl
    import pp_pkg::*;
#(
    parameter  int CHUNK_BYTES = 15360,
    parameter  int FRAME_BYTES = 153600,
    localparam int CHUNKS      = FRAME_BYTES / CHUNK_BYTES,
    localparam int CW          = idx_width(CHUNKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 stop,
    input  logic                 fill_done,
    input  logic                 drain_done,
    output logic                 fill_req,
    output logic                 fill_bank,
    output logic                 drain_req,
    output logic                 drain_bank,
    output logic                 frame_start,
    output logic [CW-1:0]        chunk_index,
    output logic [NUM_BANKS-1:0] bank_full,
    output logic                 underrun,
    output logic                 busy
);
    ctl_state_e           state;
    logic                 primed;
    logic                 clear;
    logic                 stop_exit;
    logic                 issue;
    logic [NUM_BANKS-1:0] landing;
    logic [NUM_BANKS-1:0] emptied;

    assign clear     = (state == CTL_IDLE);
    assign stop_exit = (state == CTL_STOP) && (!fill_req || fill_done);
    assign landing   = bank_mask(fill_bank, fill_req && fill_done);
    assign emptied   = bank_mask(drain_bank, drain_req && drain_done);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CTL_IDLE;
        end else begin
            case (state)
                CTL_IDLE: if (start) state <= CTL_RUN;
                CTL_RUN:  if (stop)  state <= CTL_STOP;
                CTL_STOP: if (stop_exit) state <= CTL_IDLE;
                default:  state <= CTL_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear)             primed <= 1'b0;
        else if (&bank_full)          primed <= 1'b1;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst || clear || stop_exit) bank_full[b] <= 1'b0;
            else if (landing[b])           bank_full[b] <= 1'b1;
            else if (emptied[b])           bank_full[b] <= 1'b0;
        end
    end

    pp_fill_sched u_fill (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .enable     ((state == CTL_RUN) && !stop),
        .full       (bank_full),
        .drain_req  (drain_req),
        .drain_bank (drain_bank),
        .fill_done  (fill_done),
        .fill_req   (fill_req),
        .fill_bank  (fill_bank)
    );

    pp_drain_sched u_drain (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .enable     ((state == CTL_RUN) && primed && !stop),
        .abort      (stop),
        .full       (bank_full),
        .landing    (landing),
        .drain_done (drain_done),
        .issue      (issue),
        .drain_req  (drain_req),
        .drain_bank (drain_bank),
        .underrun   (underrun)
    );

    pp_chunk_ctr #(.CHUNKS(CHUNKS), .CW(CW)) u_chunk (
        .clk         (clk),
        .rst         (rst),
        .clear       (clear),
        .issue       (issue),
        .done        (drain_req && drain_done),
        .frame_start (frame_start),
        .idx         (chunk_index)
    );

    assign busy = (state != CTL_IDLE);

endmodule

// File: rtl/pp_ctrl_checker.sv
module pp_ctrl_checker #(
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          stop,
    input logic          fill_req,
    input logic          fill_bank,
    input logic          fill_done,
    input logic          drain_req,
    input logic          drain_bank,
    input logic          drain_done,
    input logic          frame_start,
    input logic [CW-1:0] chunk_index,
    input logic [1:0]    bank_full,
    input logic          underrun,
    input logic          busy
);
    assert_bank_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        (fill_req && drain_req) |-> (fill_bank != drain_bank));

    assert_drain_on_full_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(drain_req) |-> bank_full[drain_bank]);

    assert_fill_on_empty_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(fill_req) |-> !bank_full[fill_bank]);

    assert_fill_held_R10: assert property (@(posedge clk) disable iff (rst)
        (fill_req && !fill_done) |=> (fill_req && $stable(fill_bank)));

    assert_drain_held_R10: assert property (@(posedge clk) disable iff (rst)
        (drain_req && !drain_done && !stop) |=> (drain_req && $stable(drain_bank)));

    assert_underrun_holds_R7: assert property (@(posedge clk) disable iff (rst)
        underrun |-> !drain_req);

    assert_frame_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (drain_req && chunk_index == '0));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!fill_req && !drain_req && bank_full == 2'b00));

endmodule

bind pingpong_bank_ctrl pp_ctrl_checker #(.CW(CW)) u_checker (
    .clk         (clk),
    .rst         (rst),
    .stop        (stop),
    .fill_req    (fill_req),
    .fill_bank   (fill_bank),
    .fill_done   (fill_done),
    .drain_req   (drain_req),
    .drain_bank  (drain_bank),
    .drain_done  (drain_done),
    .frame_start (frame_start),
    .chunk_index (chunk_index),
    .bank_full   (bank_full),
    .underrun    (underrun),
    .busy        (busy)
);

// File: tb/tb_pingpong_bank_ctrl.sv
`timescale 1ns/1ps
module tb_pingpong_bank_ctrl;
    localparam int CB  = 16;
    localparam int FB  = 48;
    localparam int CPF = FB / CB;
    localparam int CW  = 2;

    logic clk = 1'b0;
    logic rst, start, stop, fill_done, drain_done;
    logic fill_req, fill_bank, drain_req, drain_bank, frame_start, underrun, busy;
    logic [CW-1:0] chunk_index;
    logic [1:0] bank_full;

    always #2.5 clk = ~clk;

    pingpong_bank_ctrl #(.CHUNK_BYTES(CB), .FRAME_BYTES(FB)) dut (
        .clk(clk), .rst(rst), .start(start), .stop(stop),
        .fill_done(fill_done), .drain_done(drain_done),
        .fill_req(fill_req), .fill_bank(fill_bank),
        .drain_req(drain_req), .drain_bank(drain_bank),
        .frame_start(frame_start), .chunk_index(chunk_index),
        .bank_full(bank_full), .underrun(underrun), .busy(busy)
    );

    int n_checks = 0;
    int n_errs   = 0;
    int mem [2];
    int seq_w, seq_r, halt, underruns, exp_wr, exp_rd;

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    endtask

    task automatic do_reset();
        rst = 1'b1; start = 1'b0; stop = 1'b0; fill_done = 1'b0; drain_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic quiesce();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (!busy) break;
            if (fill_req) fill_done = 1'b1;
            @(negedge clk);
            fill_done = 1'b0;
        end
    endtask

    task automatic wait_fill_req();
        for (int i = 0; i < 20; i++) begin
            if (fill_req) break;
            @(negedge clk);
        end
    endtask

    task automatic producer(int lat);
        int cnt = 0;
        while (!halt) begin
            @(negedge clk);
            fill_done = 1'b0;
            if (fill_req) begin
                cnt++;
                if (cnt >= lat) begin
                    chk("R3", "fill bank order", int'(fill_bank), exp_wr);
                    chk("R5", "fill target empty", int'(bank_full[fill_bank]), 0);
                    mem[fill_bank] = seq_w;
                    seq_w++;
                    exp_wr ^= 1;
                    fill_done = 1'b1;
                    cnt = 0;
                end
            end
        end
        @(negedge clk);
        fill_done = 1'b0;
    endtask

    task automatic consumer(int lat, int total);
        int cnt = 0;
        bit first = 1'b1;
        bit prev_done = 1'b0;
        while (!halt) begin
            @(negedge clk);
            drain_done = 1'b0;
            if (prev_done) begin
                chk("R7", "underrun after drain", int'(underrun), int'(!bank_full[drain_bank]));
                if (underrun) underruns++;
                prev_done = 1'b0;
            end
            if (underrun) chk("R7", "consumer held", int'(drain_req), 0);
            if (fill_req && drain_req)
                chk("R4", "distinct banks", int'(fill_bank != drain_bank), 1);
            if (drain_req) begin
                chk("R5", "drain target full", int'(bank_full[drain_bank]), 1);
                cnt++;
                if (cnt == 1) begin
                    if (first) chk("R2", "both banks loaded before drain", int'(seq_w >= 2), 1);
                    first = 1'b0;
                    chk("R3", "drain bank order", int'(drain_bank), exp_rd);
                    chk("R6", "chunk order", mem[drain_bank], seq_r);
                    chk("R8", "frame_start", int'(frame_start), int'(seq_r % CPF == 0));
                    chk("R8", "chunk_index", int'(chunk_index), seq_r % CPF);
                end else begin
                    chk("R8", "frame_start single cycle", int'(frame_start), 0);
                end
                if (cnt >= lat) begin
                    drain_done = 1'b1;
                    cnt = 0;
                    seq_r++;
                    exp_rd ^= 1;
                    prev_done = 1'b1;
                    if (seq_r == total) halt = 1;
                end
            end
        end
        @(negedge clk);
        drain_done = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "fill_req", int'(fill_req), 0);
        chk("R1", "drain_req", int'(drain_req), 0);
        chk("R1", "bank_full", int'(bank_full), 0);
        chk("R1", "underrun", int'(underrun), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "frame_start", int'(frame_start), 0);
        chk("R1", "chunk_index", int'(chunk_index), 0);
    endtask

    task automatic t_stream(int fl, int dl, int total, bit slow);
        do_reset();
        seq_w = 0; seq_r = 0; halt = 0; underruns = 0; exp_wr = 0; exp_rd = 0;
        pulse_start();
        fork
            producer(fl);
            consumer(dl, total);
        join
        chk("R6", "chunks delivered", seq_r, total);
        if (slow) chk("R7", "underrun seen with slow producer", int'(underruns > 0), 1);
        else      chk("R7", "no underrun with fast producer", underruns, 0);
        quiesce();
    endtask

    task automatic t_stop_fill();
        do_reset();
        pulse_start();
        wait_fill_req();
        chk("R2", "first fill bank", int'(fill_bank), 0);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R9", "busy while fill in flight", int'(busy), 1);
        chk("R9", "no drain after stop", int'(drain_req), 0);
        repeat (3) @(negedge clk);
        chk("R9", "fill kept in flight", int'(fill_req), 1);
        fill_done = 1'b1;
        @(negedge clk);
        fill_done = 1'b0;
        chk("R9", "idle after fill", int'(busy), 0);
        chk("R9", "banks empty", int'(bank_full), 0);
        repeat (3) @(negedge clk);
        chk("R9", "no new fill when idle", int'(fill_req), 0);
        pulse_start();
        wait_fill_req();
        chk("R9", "restart fills bank 0", int'(fill_bank), 0);
        quiesce();
    endtask

    task automatic t_stop_drain();
        do_reset();
        pulse_start();
        for (int k = 0; k < 2; k++) begin
            wait_fill_req();
            @(negedge clk);
            fill_done = 1'b1;
            @(negedge clk);
            fill_done = 1'b0;
        end
        for (int i = 0; i < 10; i++) begin
            if (drain_req) break;
            @(negedge clk);
        end
        chk("R2", "drain after preload", int'(drain_req), 1);
        chk("R3", "first drain bank", int'(drain_bank), 0);
        chk("R2", "both banks full", int'(bank_full), 3);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R9", "drain dropped", int'(drain_req), 0);
        @(negedge clk);
        chk("R9", "idle after stop", int'(busy), 0);
        chk("R9", "banks cleared", int'(bank_full), 0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        t_reset();
        t_stream(3, 8, 7, 1'b0);
        t_stream(12, 4, 7, 1'b1);
        t_stop_fill();
        t_stop_drain();
        summary();
    end

endmodule